// File: doc/BRIEF.md
# Masked Unaligned Pattern Stream Checker

This block drains a circular receive byte buffer and compares the bytes in it against one of four generated data patterns. The producer advances a write pointer as it stores bytes. The checker reads whole words of the buffer and compares only the byte lanes that belong to the checked window. After each word it hands the space back by moving its own read pointer. The stream may begin at any byte alignment. A programmable number of leading bytes is discarded unchecked, then a programmable number of bytes is compared, then a programmable number of trailing bytes is discarded.

Software sets the mode, the checked length and the two skip counts, then pulses start. While the run is in progress, the block reports that it is busy and shows how many checked bytes are still to come. At the first mismatching byte it keeps a copy of the word read from the buffer and of the expected word, so the fault can be inspected after the run. Checking carries on to the end of the stream.

Top module: `pattern_stream_checker`

## Requirements
- R1: After reset, busy, err, remain, act_word, exp_word and rx_rdptr are all zero and rx_rd_en is low.
- R2: A start pulse while idle latches mode, length and both skip counts. In the next cycle busy is high, remain equals the length and err is clear. A start pulse while busy has no effect on the run or on remain.
- R3: Checked byte k of the stream (k counted from 0) is expected as follows, by mode code: 00 gives 255-(k mod 256), 01 gives k mod 256, 10 gives 0x50-(k mod 16), 11 gives 0x41+(k mod 16).
- R4: The cfg_hdr bytes that start at the read pointer, and the cfg_trl bytes that follow the cfg_len checked bytes, are consumed but never compared.
- R5: Byte address b sits in word b[13:4], lane b[3:0], bits 8*lane+7 down to 8*lane. A word is compared only in the lanes that belong to the checked window, so the first and last words of an unaligned stream are partially masked.
- R6: Each word that is processed moves rx_rdptr to the byte after the last byte taken from that word, modulo 16384. At the end of a run rx_rdptr has advanced by cfg_hdr+cfg_len+cfg_trl.
- R7: The block reads only bytes that lie between its own position and rx_wrptr. When the two are equal it issues no read and waits, even inside a word.
- R8: remain falls by the number of bytes compared. busy falls once all header, checked and trailer bytes are consumed, and remain is then zero.
- R9: The first mismatch sets err, which stays set until the next accepted start. act_word holds the raw word read and exp_word the expected word, with unchecked lanes zero. Later mismatches do not overwrite these.
- R10: rx_rd_en and rx_addr are presented in the cycle a read is issued, and rx_rdata is taken one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Pattern mode code (R3) |
| cfg_len | input | 32 | Number of bytes to compare |
| cfg_hdr | input | 14 | Leading bytes to discard |
| cfg_trl | input | 14 | Trailing bytes to discard |
| start | input | 1 | Launch a run when idle |
| busy | output | 1 | Run in progress |
| remain | output | 32 | Checked bytes still to compare |
| err | output | 1 | Sticky mismatch flag |
| act_word | output | 128 | Word read at the first mismatch |
| exp_word | output | 128 | Expected word at the first mismatch, unchecked lanes zero |
| rx_wrptr | input | 14 | Producer byte write pointer |
| rx_rdptr | output | 14 | Consumer byte read pointer |
| rx_rd_en | output | 1 | Buffer read strobe |
| rx_addr | output | 10 | Buffer word address |
| rx_rdata | input | 128 | Buffer read data, one cycle after the strobe |

## Verification
The bench sweeps all four modes over many lengths and skip counts while the stream position keeps moving around the buffer. This exercises every start alignment and the wrap at the buffer end. A design that shifted the mask by one lane, or counted the header into the pattern index, would raise err on clean data or miss the planted faults. The case of a fault in the last byte of a 451-byte unaligned stream checks the partially masked final word. Two faults in one run check that the capture keeps the first one. A producer that stops partway through a word checks that the block stalls at exactly the write pointer. It also checks that a start pulse during a run is ignored, so a design that over-read or restarted would be caught. Empty runs with only skip bytes, or with nothing at all, must still advance the pointer and release busy.

// File: rtl/psc_pkg.sv
package psc_pkg;
   typedef enum logic [1:0] {
      PAT_BIN_DN = 2'b00,
      PAT_BIN_UP = 2'b01,
      PAT_TXT_DN = 2'b10,
      PAT_TXT_UP = 2'b11
   } pat_mode_e;

   function automatic logic [7:0] pat_byte(input pat_mode_e m, input logic [7:0] k);
      logic [7:0] r;
      case (m)
         PAT_BIN_DN: r = 8'hFF - k;
         PAT_BIN_UP: r = k;
         PAT_TXT_DN: r = 8'h50 - {4'h0, k[3:0]};
         default:    r = 8'h41 + {4'h0, k[3:0]};
      endcase
      return r;
   endfunction
endpackage

// File: rtl/psc_sched.sv
module psc_sched #(
   parameter int PTR_W  = 14,
   parameter int BYTES  = 16,
   parameter int LEN_W  = 32,
   parameter int SKIP_W = 14,
   localparam int LANE_W = $clog2(BYTES),
   localparam int CNT_W  = ((LEN_W > SKIP_W) ? LEN_W : SKIP_W) + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    go,
   input  logic                    run,
   input  logic [LEN_W-1:0]        cfg_len,
   input  logic [SKIP_W-1:0]       cfg_hdr,
   input  logic [SKIP_W-1:0]       cfg_trl,
   input  logic [PTR_W-1:0]        wrptr,
   output logic                    rd_en,
   output logic [PTR_W-LANE_W-1:0] rd_addr,
   output logic                    drained,
   output logic                    s1_vld,
   output logic [BYTES-1:0]        s1_mask,
   output logic [7:0]              s1_k0,
   output logic [PTR_W-1:0]        s1_nxt
);
   logic [PTR_W-1:0]  p_q;
   logic [CNT_W-1:0]  cons_q, total_q, hdr_q, end_q;
   logic [LANE_W-1:0] off;
   logic [PTR_W-1:0]  avail;
   logic [CNT_W-1:0]  left;
   logic [LANE_W:0]   n;
   logic              issue;
   logic [BYTES-1:0]  mask;
   logic [7:0]        k0;

   always_comb begin
      logic [CNT_W-1:0] s;
      logic [LANE_W:0]  lj;
      off   = p_q[LANE_W-1:0];
      avail = wrptr - p_q;
      left  = total_q - cons_q;
      n     = (LANE_W+1)'(BYTES) - {1'b0, off};
      if (avail < PTR_W'(n)) n = avail[LANE_W:0];
      if (left < CNT_W'(n))  n = left[LANE_W:0];
      issue = run && (left != '0) && (avail != '0);
      for (int j = 0; j < BYTES; j++) begin
         lj = (LANE_W+1)'(j);
         s  = cons_q + CNT_W'(j) - CNT_W'(off);
         mask[j] = (lj >= {1'b0, off}) && (lj < ({1'b0, off} + n)) &&
                   (s >= hdr_q) && (s < end_q);
      end
      k0 = 8'(cons_q - hdr_q - CNT_W'(off));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q     <= '0;
         cons_q  <= '0;
         total_q <= '0;
         hdr_q   <= '0;
         end_q   <= '0;
         s1_vld  <= 1'b0;
         s1_mask <= '0;
         s1_k0   <= '0;
         s1_nxt  <= '0;
      end else begin
         s1_vld <= issue;
         if (go) begin
            cons_q  <= '0;
            hdr_q   <= CNT_W'(cfg_hdr);
            end_q   <= CNT_W'(cfg_hdr) + CNT_W'(cfg_len);
            total_q <= CNT_W'(cfg_hdr) + CNT_W'(cfg_len) + CNT_W'(cfg_trl);
         end else if (issue) begin
            p_q    <= p_q + PTR_W'(n);
            cons_q <= cons_q + CNT_W'(n);
         end
         if (issue) begin
            s1_mask <= mask;
            s1_k0   <= k0;
            s1_nxt  <= p_q + PTR_W'(n);
         end
      end
   end

   assign rd_en   = issue;
   assign rd_addr = p_q[PTR_W-1:LANE_W];
   assign drained = (left == '0);
endmodule

// File: rtl/psc_lane.sv
module psc_lane
   import psc_pkg::*;
(
   input  pat_mode_e  mode,
   input  logic [7:0] k,
   input  logic       chk,
   input  logic [7:0] act,
   output logic [7:0] exp_o,
   output logic       bad
);
   logic [7:0] want;
   assign want  = pat_byte(mode, k);
   assign exp_o = chk ? want : 8'h00;
   assign bad   = chk && (act != want);
endmodule

// File: rtl/pattern_stream_checker.sv
module pattern_stream_checker
   import psc_pkg::*;
#(
   parameter int PTR_W  = 14,
   parameter int BYTES  = 16,
   parameter int LEN_W  = 32,
   parameter int SKIP_W = 14,
   localparam int LANE_W  = $clog2(BYTES),
   localparam int DATA_W  = BYTES * 8,
   localparam int WADDR_W = PTR_W - LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         cfg_mode,
   input  logic [LEN_W-1:0]   cfg_len,
   input  logic [SKIP_W-1:0]  cfg_hdr,
   input  logic [SKIP_W-1:0]  cfg_trl,
   input  logic               start,
   output logic               busy,
   output logic [LEN_W-1:0]   remain,
   output logic               err,
   output logic [DATA_W-1:0]  act_word,
   output logic [DATA_W-1:0]  exp_word,
   input  logic [PTR_W-1:0]   rx_wrptr,
   output logic [PTR_W-1:0]   rx_rdptr,
   output logic               rx_rd_en,
   output logic [WADDR_W-1:0] rx_addr,
   input  logic [DATA_W-1:0]  rx_rdata
);
   if (BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_bytes
      $error("BYTES must be a power of two of at least 2");
   end
   if (PTR_W <= LANE_W + 1) begin : g_bad_ptr
      $error("PTR_W must exceed the lane index width by more than one");
   end

   logic              go, drained, s1_vld, any_bad;
   logic [BYTES-1:0]  s1_mask, bad_vec;
   logic [7:0]        s1_k0;
   logic [PTR_W-1:0]  s1_nxt;
   logic [DATA_W-1:0] exp_vec;
   logic [LANE_W:0]   cnt;
   pat_mode_e         mode_q;

   assign go = start && !busy;

   psc_sched #(.PTR_W(PTR_W), .BYTES(BYTES), .LEN_W(LEN_W), .SKIP_W(SKIP_W)) sched_i (
      .clk(clk), .rst_n(rst_n), .go(go), .run(busy),
      .cfg_len(cfg_len), .cfg_hdr(cfg_hdr), .cfg_trl(cfg_trl), .wrptr(rx_wrptr),
      .rd_en(rx_rd_en), .rd_addr(rx_addr), .drained(drained),
      .s1_vld(s1_vld), .s1_mask(s1_mask), .s1_k0(s1_k0), .s1_nxt(s1_nxt)
   );

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      psc_lane lane_i (
         .mode(mode_q), .k(s1_k0 + 8'(g)), .chk(s1_mask[g]),
         .act(rx_rdata[8*g +: 8]), .exp_o(exp_vec[8*g +: 8]), .bad(bad_vec[g])
      );
   end

   assign any_bad = s1_vld && (bad_vec != '0);

   always_comb begin
      cnt = '0;
      for (int j = 0; j < BYTES; j++) cnt = cnt + (LANE_W+1)'(s1_mask[j]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         mode_q   <= PAT_BIN_DN;
         remain   <= '0;
         err      <= 1'b0;
         act_word <= '0;
         exp_word <= '0;
         rx_rdptr <= '0;
      end else begin
         if (go) begin
            busy     <= 1'b1;
            mode_q   <= pat_mode_e'(cfg_mode);
            remain   <= cfg_len;
            err      <= 1'b0;
            act_word <= '0;
            exp_word <= '0;
         end else begin
            if (busy && drained && !s1_vld) busy <= 1'b0;
            if (s1_vld) begin
               remain   <= remain - LEN_W'(cnt);
               rx_rdptr <= s1_nxt;
            end
            if (any_bad) begin
               err <= 1'b1;
               if (!err) begin
                  act_word <= rx_rdata;
                  exp_word <= exp_vec;
               end
            end
         end
      end
   end
endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
   parameter int PTR_W  = 14,
   parameter int BYTES  = 16,
   parameter int LEN_W  = 32,
   localparam int DATA_W = BYTES * 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [LEN_W-1:0]  cfg_len,
   input logic              busy,
   input logic [LEN_W-1:0]  remain,
   input logic              err,
   input logic [DATA_W-1:0] act_word,
   input logic [DATA_W-1:0] exp_word,
   input logic [PTR_W-1:0]  rx_wrptr,
   input logic [PTR_W-1:0]  rx_rdptr,
   input logic              rx_rd_en
);
   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && remain == $past(cfg_len) && !err)); // R2
   AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rx_rd_en); // R8
   AST_READ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd_en |-> (rx_wrptr != rx_rdptr)); // R7
   AST_RDPTR_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(rx_rdptr)); // R6
   AST_REMAIN_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (remain <= $past(remain))); // R8
   AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (remain == '0)); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && err) |=> err); // R9
   AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(start && !busy)) |=> ($stable(act_word) && $stable(exp_word))); // R9
endmodule

bind pattern_stream_checker psc_chk #(.PTR_W(PTR_W), .BYTES(BYTES), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/pattern_stream_checker_tb.sv
module pattern_stream_checker_tb_top;
   localparam int BUFSZ = 16384;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   cfg_mode = '0;
   logic [31:0]  cfg_len = '0;
   logic [13:0]  cfg_hdr = '0;
   logic [13:0]  cfg_trl = '0;
   logic         start = 1'b0;
   logic         busy, err, rx_rd_en;
   logic [31:0]  remain;
   logic [127:0] act_word, exp_word;
   logic [13:0]  rx_wrptr = '0;
   logic [13:0]  rx_rdptr;
   logic [9:0]   rx_addr;
   logic [127:0] rx_rdata = '0;
   logic [127:0] mem [0:1023];

   int n_chk = 0;
   int n_bad = 0;
   int wp = 0;

   always #10 clk = ~clk;

   always @(posedge clk) if (rx_rd_en) rx_rdata <= mem[rx_addr];

   pattern_stream_checker dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
      .cfg_hdr(cfg_hdr), .cfg_trl(cfg_trl), .start(start), .busy(busy),
      .remain(remain), .err(err), .act_word(act_word), .exp_word(exp_word),
      .rx_wrptr(rx_wrptr), .rx_rdptr(rx_rdptr), .rx_rd_en(rx_rd_en),
      .rx_addr(rx_addr), .rx_rdata(rx_rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] a, input logic [127:0] e);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, a, e);
      end
   endtask

   function automatic logic [7:0] epat(input int m, input int k);
      case (m)
         0: return 8'(255 - (k % 256));
         1: return 8'(k % 256);
         2: return 8'(80 - (k % 16));
         default: return 8'(65 + (k % 16));
      endcase
   endfunction

   task automatic put(input int a, input logic [7:0] v);
      mem[a / 16][8 * (a % 16) +: 8] = v;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic run(input int mode, input int len, input int hdr, input int trl,
                      input int c1, input int c2, input int staged);
      int base, total, t, done_chk;
      logic [127:0] ew, aw;
      base  = wp;
      total = hdr + len + trl;
      for (int i = 0; i < hdr; i++) put((base + i) % BUFSZ, 8'(8'hE7 ^ i));
      for (int i = 0; i < len; i++) put((base + hdr + i) % BUFSZ, epat(mode, i));
      for (int i = 0; i < trl; i++) put((base + hdr + len + i) % BUFSZ, 8'(8'h3C + 3 * i));
      if (c1 >= 0) put((base + hdr + c1) % BUFSZ, epat(mode, c1) ^ 8'h01);
      if (c2 >= 0) put((base + hdr + c2) % BUFSZ, epat(mode, c2) ^ 8'h80);
      ew = '0; aw = '0;
      if (c1 >= 0) begin
         int a, w;
         a = (base + hdr + c1) % BUFSZ;
         w = a / 16;
         for (int j = 0; j < 16; j++) begin
            int d;
            d = (w * 16 + j - base + BUFSZ) % BUFSZ;
            if (d >= hdr && d < hdr + len) ew[8*j +: 8] = epat(mode, d - hdr);
         end
         aw = mem[w];
      end
      @(negedge clk);
      cfg_mode = 2'(mode); cfg_len = 32'(len); cfg_hdr = 14'(hdr); cfg_trl = 14'(trl);
      rx_wrptr = 14'((base + (staged > 0 ? staged : total)) % BUFSZ);
      pulse_start();
      chk(busy === 1'b1 && remain === 32'(len) && err === 1'b0, "R2 start loads run",
          {busy, remain, err}, {1'b1, 32'(len), 1'b0});
      if (staged > 0) begin
         int seen;
         repeat (30) @(negedge clk);
         seen = staged - hdr;
         if (seen < 0) seen = 0;
         if (seen > len) seen = len;
         chk(rx_rdptr === 14'((base + staged) % BUFSZ), "R7 stall at write pointer",
             128'(rx_rdptr), 128'((base + staged) % BUFSZ));
         chk(busy === 1'b1 && rx_rd_en === 1'b0, "R7 no read while empty",
             {busy, rx_rd_en}, 2'b10);
         chk(remain === 32'(len - seen), "R8 partial remain", 128'(remain), 128'(len - seen));
         cfg_len = 32'd7;
         pulse_start();
         @(negedge clk);
         chk(remain === 32'(len - seen) && busy === 1'b1, "R2 start ignored while busy",
             128'(remain), 128'(len - seen));
         rx_wrptr = 14'((base + total) % BUFSZ);
      end
      t = 0;
      while (busy && t < 4000) begin
         @(negedge clk);
         t++;
      end
      chk(busy === 1'b0, "R8 busy falls at end", 128'(busy), 128'(0));
      chk(remain === 32'd0, "R8 remain reaches zero", 128'(remain), 128'(0));
      chk(rx_rdptr === 14'((base + total) % BUFSZ), "R6 read pointer advanced",
          128'(rx_rdptr), 128'((base + total) % BUFSZ));
      done_chk = (c1 >= 0) ? 1 : 0;
      chk(err === 1'(done_chk), "R3 R4 R10 mismatch flag", 128'(err), 128'(done_chk));
      if (c1 >= 0) begin
         chk(act_word === aw, "R9 captured actual word", act_word, aw);
         chk(exp_word === ew, "R5 captured expected word", exp_word, ew);
      end
      wp = (base + total) % BUFSZ;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && err === 1'b0 && rx_rd_en === 1'b0, "R1 reset flags",
          {busy, err, rx_rd_en}, 3'b000);
      chk(remain === 32'd0 && rx_rdptr === 14'd0, "R1 reset counters",
          {remain, rx_rdptr}, 46'd0);
      chk(act_word === '0 && exp_word === '0, "R1 reset capture", act_word | exp_word, '0);

      for (int m = 0; m < 4; m++) begin
         for (int len = 0; len <= 40; len += 3) begin
            run(m, len, (len * 7 + m) % 23, (len * 5) % 19, -1, -1, 0);
         end
      end
      run(1, 0, 0, 0, -1, -1, 0);
      run(2, 0, 5, 3, -1, -1, 0);
      run(3, 451, ((15 - (wp % 16) + 16) % 16) + 16, 4, 450, -1, 0);
      run(0, 300, 0, 0, 0, 200, 0);
      run(2, 100, 9, 30, 57, -1, 0);
      run(1, 40, 3, 2, -1, -1, 10);
      run(3, 64, 17, 5, 31, 60, 0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule